// File: doc/BRIEF.md
# Aligned Glitch-Free Dual Clock Divider

This block produces two divided clocks from one oscillator. Each divider takes an 8-bit ratio code whose three most significant bits pick one of eight divide values (1, 2, 3, 4, 5, 6, 8, 16). Every divided waveform is derived from a common bank of phase counters that all start together at reset. As a result, the rising edges of any two outputs coincide wherever their periods meet.

The block is clocked by a tick clock `clk_i` that runs at twice the oscillator rate, so one tick is one oscillator half-period. A divide value of N then gives an output period of 2N ticks, with N ticks high and N ticks low. That holds for odd values as well, and a divide value of 1 reproduces the oscillator waveform.

A ratio change never cuts a pulse short. The output finishes its current period at the old ratio, stays low, and resumes at the first rising edge of the new ratio on the shared grid. Output 1 can follow either divider. A global force-low bit parks both clocks low. A per-output enable, when cleared, raises a high-impedance indication that takes priority over force-low. All controls are plain level inputs. The block has no data stream, so there is no valid/ready handshake.

Top module: `aclk_div_top`

## Requirements
- R1: The divide value is selected by code bits [7:5] only: 000→1, 001→2, 010→3, 011→4, 100→5, 101→6, 110→8, 111→16. Code bits [4:0] have no effect on the outputs. A divider at value N repeats with a period of 2N ticks of `clk_i`.
- R2: Each divider's rising edges fall at tick counts since reset that are whole multiples of 2N, offset by the fixed two-tick output latency. The outputs of two dividers therefore rise together whenever their grids meet.
- R3: When a divider's code changes, the divider completes its current period at the old value. It then holds low until the first rising edge of the new value's grid and follows the new value from that edge on. A code that changes again while the divider is holding replaces the pending value.
- R4: `clk0_o` always follows divider 0. `clk1_o` follows divider 0 when `out1_src_i` is 0 and divider 1 when it is 1.
- R5: While `force_low_i` is 1, both clock outputs are 0 one tick later.
- R6: `oe0_i`=0 makes `clk0_oe_o`=0, and `oe1_i`=0 makes `clk1_oe_o`=0. The matching clock output is also driven 0 one tick later, whatever `force_low_i` is. An enable of 1 makes the matching flag 1.
- R7: While reset is asserted, both clock outputs are 0 and both enable flags are 1. After reset both dividers run at divide value 1.
- R8: For every divide value, odd ones included, an output period is N ticks high followed by N ticks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the oscillator rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div0_code_i | input | CODE_W | Ratio code for divider 0; bits [7:5] used |
| div1_code_i | input | CODE_W | Ratio code for divider 1; bits [7:5] used |
| out1_src_i | input | 1 | 0: output 1 follows divider 0, 1: follows divider 1 |
| force_low_i | input | 1 | Hold both clock outputs low |
| oe0_i | input | 1 | Enable for output 0; 0 means high impedance |
| oe1_i | input | 1 | Enable for output 1; 0 means high impedance |
| clk0_o | output | 1 | Divided clock output 0 |
| clk0_oe_o | output | 1 | Drive-enable flag for output 0 |
| clk1_o | output | 1 | Divided clock output 1 |
| clk1_oe_o | output | 1 | Drive-enable flag for output 1 |

## Verification
The bench builds the block with the default `CODE_W` of 8. This lets it place varying patterns in the five ignored code bits while cycling through all eight divide values. Because the largest value is 16, the phase bank repeats every 480 ticks. A few thousand ticks therefore cover many full alignment cycles, including the cases where values such as 3 and 16 share a rising edge only rarely. Code changes are injected at varying offsets within a period, so a ratio switch is exercised both when the new grid's edge arrives at once and when the divider has to hold low for many ticks.

// File: rtl/aclk_div_pkg.sv
package aclk_div_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_RATIO = 1 << SEL_W;
  localparam int unsigned MAX_RATIO = 16;
  localparam int unsigned PH_W      = $clog2(2 * MAX_RATIO);

  function automatic int unsigned ratio_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      3'd4:    return 5;
      3'd5:    return 6;
      3'd6:    return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/aclk_phase_bank.sv
module aclk_phase_bank
  import aclk_div_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic [NUM_RATIO-1:0] wave_o,
  output logic [NUM_RATIO-1:0] first_o,
  output logic [NUM_RATIO-1:0] last_o
);
  for (genvar k = 0; k < NUM_RATIO; k++) begin : g_ph
    localparam int unsigned HALF = ratio_of(SEL_W'(k));
    localparam logic [PH_W-1:0] TOP = PH_W'(2 * HALF - 1);
    logic [PH_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (cnt_q == TOP) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end

    assign wave_o[k]  = (cnt_q < PH_W'(HALF));
    assign first_o[k] = (cnt_q == '0);
    assign last_o[k]  = (cnt_q == TOP);
  end

  // R2: power-of-two grids nest inside the divide-by-16 grid
  a_r2_grid_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o[7] |-> (first_o[0] && first_o[1] && first_o[3] && first_o[6]));
endmodule

// File: rtl/aclk_div_lane.sv
module aclk_div_lane
  import aclk_div_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_RATIO-1:0] wave_i,
  input  logic [NUM_RATIO-1:0] first_i,
  input  logic [NUM_RATIO-1:0] last_i,
  output logic                 q_o
);
  logic [SEL_W-1:0] act_q, act_d, pend_q, pend_d;
  logic             hold_q, hold_d;
  logic             drive;

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    hold_d = hold_q;
    drive  = wave_i[act_q];
    if (!hold_q) begin
      if (sel_i != act_q && last_i[act_q]) begin
        hold_d = 1'b1;
        pend_d = sel_i;
      end
    end else if (first_i[pend_q]) begin
      drive  = wave_i[pend_q];
      act_d  = pend_q;
      hold_d = 1'b0;
    end else begin
      drive  = 1'b0;
      pend_d = sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= '0;
      hold_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      hold_q <= hold_d;
      q_o    <= drive;
    end
  end

  // R3: the lane output stays low during the hold gap
  a_r3_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !q_o);
  // R3: a new ratio takes over exactly on one of its rising edges
  a_r3_switch_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> q_o);
endmodule

// File: rtl/aclk_div_top.sv
module aclk_div_top
  import aclk_div_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div0_code_i,
  input  logic [CODE_W-1:0] div1_code_i,
  input  logic              out1_src_i,
  input  logic              force_low_i,
  input  logic              oe0_i,
  input  logic              oe1_i,
  output logic              clk0_o,
  output logic              clk0_oe_o,
  output logic              clk1_o,
  output logic              clk1_oe_o
);
  localparam int unsigned LOW_W = CODE_W - SEL_W;

  logic [NUM_RATIO-1:0] wave, first, last;
  logic [1:0]           lane_q;
  logic [SEL_W-1:0]     sel [2];
  logic                 unused_low_bits;

  assign sel[0] = div0_code_i[CODE_W-1 -: SEL_W];
  assign sel[1] = div1_code_i[CODE_W-1 -: SEL_W];
  assign unused_low_bits = ^{div0_code_i[LOW_W-1:0], div1_code_i[LOW_W-1:0]};

  aclk_phase_bank u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wave_o (wave),
    .first_o(first),
    .last_o (last)
  );

  for (genvar d = 0; d < 2; d++) begin : g_lane
    aclk_div_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel[d]),
      .wave_i (wave),
      .first_i(first),
      .last_i (last),
      .q_o    (lane_q[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk0_o    <= 1'b0;
      clk1_o    <= 1'b0;
      clk0_oe_o <= 1'b1;
      clk1_oe_o <= 1'b1;
    end else begin
      clk0_o    <= oe0_i && !force_low_i && lane_q[0];
      clk1_o    <= oe1_i && !force_low_i && (out1_src_i ? lane_q[1] : lane_q[0]);
      clk0_oe_o <= oe0_i;
      clk1_oe_o <= oe1_i;
    end
  end

  // R5: force-low silences both clocks
  a_r5_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_i |=> (!clk0_o && !clk1_o));
  // R6: a cleared enable wins over everything on that output
  a_r6_hiz0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe0_i |=> (!clk0_oe_o && !clk0_o));
  a_r6_hiz1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe1_i |=> (!clk1_oe_o && !clk1_o));
  // R4: with both outputs on divider 0 and nothing masking, they match
  a_r4_shared_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out1_src_i && oe0_i && oe1_i) |=> (clk0_o == clk1_o));
endmodule

// File: tb/sim_aclk_div_top.sv
`timescale 1ns/1ps
module sim_aclk_div_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code0 = '0, code1 = '0;
  logic       route = 1'b0, force_lo = 1'b0, en0 = 1'b1, en1 = 1'b1;
  logic       clk0, oe0f, clk1, oe1f;

  int    checks = 0, errors = 0;
  string cur_req = "R7";
  bit    cmp_on = 1'b0;

  always #2 clk = ~clk;

  aclk_div_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .div0_code_i(code0), .div1_code_i(code1),
    .out1_src_i(route), .force_low_i(force_lo), .oe0_i(en0), .oe1_i(en1),
    .clk0_o(clk0), .clk0_oe_o(oe0f), .clk1_o(clk1), .clk1_oe_o(oe1f)
  );

  function automatic int rat(input logic [2:0] c);
    int t [8] = '{1, 2, 3, 4, 5, 6, 8, 16};
    return t[c];
  endfunction

  // Behavioural reference: global tick count, per-output pending state
  int g;
  int act [2], pend [2];
  bit hold [2], qd [2];
  bit e_clk0, e_clk1, e_oe0, e_oe1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g = 0;
      for (int d = 0; d < 2; d++) begin act[d] = 0; pend[d] = 0; hold[d] = 0; qd[d] = 0; end
      e_clk0 = 0; e_clk1 = 0; e_oe0 = 1; e_oe1 = 1;
    end else begin
      e_clk0 = en0 && !force_lo && qd[0];
      e_clk1 = en1 && !force_lo && (route ? qd[1] : qd[0]);
      e_oe0  = en0;
      e_oe1  = en1;
      for (int d = 0; d < 2; d++) begin
        int want, n, ph;
        bit drv;
        want = (d == 0) ? int'(code0[7:5]) : int'(code1[7:5]);
        if (!hold[d]) begin
          n = rat(3'(act[d]));
          ph = g % (2 * n);
          drv = (ph < n);
          if (want != act[d] && ph == 2 * n - 1) begin hold[d] = 1; pend[d] = want; end
        end else begin
          n = rat(3'(pend[d]));
          if (g % (2 * n) == 0) begin drv = 1; act[d] = pend[d]; hold[d] = 0; end
          else begin drv = 0; pend[d] = want; end
        end
        qd[d] = drv;
      end
      g = (g + 1) % 480;
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(cur_req, "clk0", clk0, e_clk0);
      check(cur_req, "clk1", clk1, e_clk1);
      check(cur_req, "oe0", oe0f, e_oe0);
      check(cur_req, "oe1", oe1f, e_oe1);
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R8: measure one high and one low run on clk0 directly
  task automatic duty(input logic [2:0] c);
    int h = 0, l = 0, guard = 0;
    code0 = {c, 5'b10101};
    ticks(80);
    while (clk0 && guard < 100) begin guard++; @(negedge clk); end
    while (!clk0 && guard < 200) begin guard++; @(negedge clk); end
    while (clk0 && guard < 300) begin h++; guard++; @(negedge clk); end
    while (!clk0 && guard < 400) begin l++; guard++; @(negedge clk); end
    check("R8", "high run", 1'(h == rat(c)), 1'b1);
    check("R8", "low run", 1'(l == rat(c)), 1'b1);
    if (h != rat(c) || l != rat(c))
      $display("  R8 detail: high %0d low %0d expected %0d", h, l, rat(c));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ticks(3);
    cur_req = "R7";
    check("R7", "reset clk0", clk0, 1'b0);
    check("R7", "reset clk1", clk1, 1'b0);
    check("R7", "reset oe0", oe0f, 1'b1);
    check("R7", "reset oe1", oe1f, 1'b1);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    ticks(12);

    cur_req = "R1";
    route = 1'b1;
    for (int c = 0; c < 8; c++) begin
      code0 = {3'(c), 5'(c * 7)};
      code1 = {3'(7 - c), 5'h1f};
      ticks(80);
      code0[4:0] = ~code0[4:0];
      ticks(40);
    end

    cur_req = "R2";
    code0 = {3'd1, 5'd0}; code1 = {3'd3, 5'd0};
    ticks(100);
    code0 = {3'd2, 5'd0}; code1 = {3'd5, 5'd0};
    ticks(100);
    code0 = {3'd2, 5'd0}; code1 = {3'd7, 5'd0};
    ticks(500);

    cur_req = "R3";
    for (int i = 0; i < 30; i++) begin
      code0 = {3'(i * 5), 5'd0};
      if (i % 3 == 0) code1 = {3'(i), 5'd3};
      ticks((i % 7) + 3);
    end
    ticks(60);

    cur_req = "R4";
    code0 = {3'd1, 5'd0}; code1 = {3'd4, 5'd0};
    for (int i = 0; i < 8; i++) begin route = ~route; ticks(13); end

    cur_req = "R5";
    for (int i = 0; i < 4; i++) begin force_lo = 1'b1; ticks(30); force_lo = 1'b0; ticks(17); end

    cur_req = "R6";
    en0 = 1'b0; ticks(25);
    force_lo = 1'b1; ticks(20);
    en1 = 1'b0; ticks(20);
    force_lo = 1'b0; ticks(20);
    en0 = 1'b1; ticks(20);
    en1 = 1'b1; ticks(20);

    cmp_on = 1'b0;
    duty(3'd2);
    duty(3'd4);
    duty(3'd0);
    duty(3'd7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule